// File: doc/BRIEF.md
# Bus Ownership Handshake Controller

This block decides, cycle by cycle, whether the local processor core or a single external device drives a shared bus. An external device asks for the bus on an active-low request line. The controller answers on an active-low grant line. The device then confirms that it has taken over on an active-low acknowledge line. The local core is always the lowest-priority master. Any pending external request therefore wins at the next point where no operand is in flight. That point is either an end-of-operand strobe from the bus sequencer or the halted state of the core.

The request and acknowledge lines come from outside the clock domain, so each passes through a two-flop synchronizer before the state machine sees it. While the external master holds the bus, the controller turns the grant off a fixed number of clocks after the acknowledge edge. If a request is still pending, it turns the grant on again after a second fixed delay, so that outside logic can line up the next master early. Once the acknowledge and the request are both gone and the grant is off, ownership returns to the core. While the bus is away, the core's address and control drivers are disabled. If the core is still halted when the bus comes back, the drivers present the values they carried before the handover, taken from a holding register.

Top module: `busown_ctrl`

## Requirements
- R1: While reset is low, and on the first cycle after it, grant_n is 1, local_owner is 1 and drv_oe is 1.
- R2: A pending request does not produce a grant while no boundary is signalled and halt is 0. The grant (grant_n = 0) appears on the clock edge that samples xfer_end = 1 while the synchronized request is pending.
- R3: While halt is 1, a pending request is granted without any xfer_end pulse.
- R4: When the grant is issued, local_owner and drv_oe fall on the same edge. local_owner is never 1 while grant_n is 0.
- R5: After the synchronized acknowledge is seen, grant_n returns to 1 exactly NEG_DLY clocks later, even when a request is still pending.
- R6: With the acknowledge still held and a request pending, grant_n returns to 0 exactly REGRANT_DLY clocks after it was negated.
- R7: If the request is withdrawn while granted and before any acknowledge, grant_n goes to 1 and local_owner to 1 one clock after the withdrawal is synchronized.
- R8: local_owner and drv_oe return to 1 one clock after the controller sees acknowledge inactive, request inactive and grant negated. They never return while grant_n is 0.
- R9: If halt is 1 when ownership returns, bus_out shows the value core_bus had on the last cycle the core owned the bus. Once halt falls, bus_out follows core_bus again from the next clock edge.
- R10: If the current master releases the acknowledge while a re-issued grant is held and a request is pending, the grant stays asserted and the core does not regain the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_n | input | 1 | External bus request, active low, asynchronous |
| ack_n | input | 1 | Grant acknowledge from the external master, active low, asynchronous |
| xfer_end | input | 1 | Pulse from the bus sequencer marking the end of an operand transfer |
| halt | input | 1 | Core halted, including a stop after a double bus fault |
| core_bus | input | BW | Address and control values the core wants to drive |
| grant_n | output | 1 | Bus grant, active low |
| drv_oe | output | 1 | Enable for the core's address and control drivers (0 = high impedance) |
| local_owner | output | 1 | The core owns the bus |
| bus_out | output | BW | Address and control values presented to the drivers |

## Verification
Each result has a fixed latency. Request and acknowledge changes pass two synchronizer flops and then the state register. A grant or release therefore shows up three edges after the input changes. The boundary strobe and halt act on the next edge. The grant negation and the re-grant land NEG_DLY and REGRANT_DLY edges after that. The bench drives and samples on falling edges. It checks each output both one edge before and on the edge where the change is due, so a result that comes early or late by one clock is caught. The boundary delay is swept over several lengths, and the delays are set to different values so that they cannot be confused with each other.

// File: rtl/busown_pkg.sv
// Shared types for the bus ownership controller.
package busown_pkg;
    // Arbitration phases; the core owns the bus in ARB_IDLE and ARB_WAIT.
    typedef enum logic [2:0] {
        ARB_IDLE  = 3'd0,
        ARB_WAIT  = 3'd1,
        ARB_GRANT = 3'd2,
        ARB_EXT   = 3'd3,
        ARB_REL   = 3'd4
    } arb_state_e;
endpackage

// File: rtl/busown_sync.sv
// Multi-stage synchronizer for asynchronous control lines.
// Assumes: each bit is independent; RST_VAL is the inactive level.
module busown_sync #(
    parameter int          WIDTH   = 2,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] stg_q;

    // Shift the raw input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_q <= {STAGES{RST_VAL}};
        end else begin
            stg_q[0] <= din;
            for (int i = 1; i < STAGES; i++) begin
                stg_q[i] <= stg_q[i-1];
            end
        end
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/busown_fsm.sv
// Ownership state machine: waits for an operand boundary, grants,
// negates the grant NEG_DLY clocks after acknowledge, re-grants after
// REGRANT_DLY clocks while requests remain, and returns the bus.
// Assumes: req/ack inputs are already synchronized and active high.
module busown_fsm
    import busown_pkg::*;
#(
    parameter int NEG_DLY     = 2,
    parameter int REGRANT_DLY = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_s,
    input  logic ack_s,
    input  logic xfer_end,
    input  logic halt,
    output logic grant,
    output logic core_own
);
    localparam int MAXD = (NEG_DLY > REGRANT_DLY) ? NEG_DLY : REGRANT_DLY;
    localparam int CW   = (MAXD < 2) ? 1 : $clog2(MAXD);
    localparam logic [CW-1:0] NEG_LAST = CW'(NEG_DLY - 1);
    localparam logic [CW-1:0] RG_LAST  = CW'(REGRANT_DLY - 1);

    arb_state_e    st_q, st_d;
    logic          gnt_q, gnt_d;
    logic          win_q, win_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // Next-state, grant and delay-counter decisions.
    always_comb begin
        st_d  = st_q;
        gnt_d = gnt_q;
        win_d = win_q;
        cnt_d = cnt_q;
        unique case (st_q)
            ARB_IDLE: begin
                if (req_s) st_d = ARB_WAIT;
            end
            ARB_WAIT: begin
                if (!req_s) begin
                    st_d = ARB_IDLE;
                end else if (xfer_end || halt) begin
                    st_d  = ARB_GRANT;
                    gnt_d = 1'b1;
                end
            end
            ARB_GRANT: begin
                if (ack_s) begin
                    st_d  = ARB_EXT;
                    win_d = 1'b1;
                    cnt_d = '0;
                end else if (!req_s) begin
                    st_d  = ARB_IDLE;
                    gnt_d = 1'b0;
                end
            end
            ARB_EXT: begin
                if (!ack_s) begin
                    win_d = 1'b0;
                    cnt_d = '0;
                    if (gnt_q && req_s) begin
                        st_d = ARB_GRANT;
                    end else begin
                        st_d  = ARB_REL;
                        gnt_d = 1'b0;
                    end
                end else if (win_q) begin
                    if (cnt_q == NEG_LAST) begin
                        gnt_d = 1'b0;
                        win_d = 1'b0;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end else if (gnt_q) begin
                    if (!req_s) gnt_d = 1'b0;
                end else if (req_s) begin
                    if (cnt_q == RG_LAST) begin
                        gnt_d = 1'b1;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end else begin
                    cnt_d = '0;
                end
            end
            ARB_REL: begin
                if (req_s) begin
                    st_d  = ARB_GRANT;
                    gnt_d = 1'b1;
                end else begin
                    st_d = ARB_IDLE;
                end
            end
            default: begin
                st_d  = ARB_IDLE;
                gnt_d = 1'b0;
            end
        endcase
    end

    // State and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ARB_IDLE;
            gnt_q <= 1'b0;
            win_q <= 1'b0;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            gnt_q <= gnt_d;
            win_q <= win_d;
            cnt_q <= cnt_d;
        end
    end

    assign grant    = gnt_q;
    assign core_own = (st_q == ARB_IDLE) || (st_q == ARB_WAIT);
endmodule

// File: rtl/busown_hold.sv
// Holding register for the core's bus values: tracks them while the
// core owns the bus, and replays them when the bus returns during halt.
// Assumes: own changes only on clock edges.
module busown_hold #(
    parameter int BW = 30
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          own,
    input  logic          halt,
    input  logic [BW-1:0] core_bus,
    output logic [BW-1:0] bus_out
);
    logic [BW-1:0] held_q;
    logic          restore_q;

    // Capture driven values while owned and not replaying.
    always_ff @(posedge clk) begin
        if (!rst_n)                 held_q <= '0;
        else if (own && !restore_q) held_q <= core_bus;
    end

    // Replay flag: armed by halt while away, cleared when halt drops.
    always_ff @(posedge clk) begin
        if (!rst_n)     restore_q <= 1'b0;
        else if (!own)  restore_q <= halt;
        else if (!halt) restore_q <= 1'b0;
    end

    assign bus_out = (own && !restore_q) ? core_bus : held_q;
endmodule

// File: rtl/busown_ctrl.sv
// Top of the bus ownership controller: synchronizes the external
// handshake lines, runs the ownership state machine and controls the
// core's drivers. Assumes a single clock and synchronous reset.
module busown_ctrl #(
    parameter int BW          = 30,
    parameter int SYNC_STAGES = 2,
    parameter int NEG_DLY     = 2,
    parameter int REGRANT_DLY = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_n,
    input  logic          ack_n,
    input  logic          xfer_end,
    input  logic          halt,
    input  logic [BW-1:0] core_bus,
    output logic          grant_n,
    output logic          drv_oe,
    output logic          local_owner,
    output logic [BW-1:0] bus_out
);
    logic [1:0] raw_n, sync_n;
    logic       req_s, ack_s, grant, core_own;

    assign raw_n = {ack_n, req_n};

    busown_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw_n),
        .dout (sync_n)
    );

    assign req_s = ~sync_n[0];
    assign ack_s = ~sync_n[1];

    busown_fsm #(.NEG_DLY(NEG_DLY), .REGRANT_DLY(REGRANT_DLY)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_s   (req_s),
        .ack_s   (ack_s),
        .xfer_end(xfer_end),
        .halt    (halt),
        .grant   (grant),
        .core_own(core_own)
    );

    busown_hold #(.BW(BW)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .own     (core_own),
        .halt    (halt),
        .core_bus(core_bus),
        .bus_out (bus_out)
    );

    assign grant_n     = ~grant;
    assign local_owner = core_own;
    assign drv_oe      = core_own;
endmodule

// File: rtl/busown_ctrl_chk.sv
// Protocol checker for busown_ctrl, attached by bind.
module busown_ctrl_chk #(
    parameter int BW = 30
) (
    input logic          clk,
    input logic          rst_n,
    input logic          xfer_end,
    input logic          halt,
    input logic          grant_n,
    input logic          local_owner,
    input logic [BW-1:0] bus_out
);
    // R4
    owner_grant_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(local_owner && !grant_n));

    // R4
    handover_grants_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(local_owner) |-> !grant_n);

    // R2
    grant_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(grant_n) && $past(local_owner)) |-> $past(xfer_end || halt));

    // R8
    return_ungranted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(local_owner) |-> grant_n);

    // R9
    halt_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(local_owner) && $past(halt)) |-> $stable(bus_out));
endmodule

bind busown_ctrl busown_ctrl_chk #(.BW(BW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .xfer_end   (xfer_end),
    .halt       (halt),
    .grant_n    (grant_n),
    .local_owner(local_owner),
    .bus_out    (bus_out)
);

// File: tb/tb_busown_ctrl.sv
`timescale 1ns/1ps
// Self-checking bench for busown_ctrl; drives and samples on falling edges.
module tb_busown_ctrl;
    localparam int BW  = 30;
    localparam int NEG = 2;
    localparam int RG  = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_n = 1'b1, ack_n = 1'b1, xfer_end = 1'b0, halt = 1'b0;
    logic [BW-1:0] core_bus = '0;
    logic          grant_n, drv_oe, local_owner;
    logic [BW-1:0] bus_out;
    int            n_chk = 0, n_fail = 0;
    logic          done = 1'b0;

    always #2 clk = ~clk;

    busown_ctrl #(.BW(BW), .SYNC_STAGES(2), .NEG_DLY(NEG), .REGRANT_DLY(RG)) dut (
        .clk(clk), .rst_n(rst_n), .req_n(req_n), .ack_n(ack_n),
        .xfer_end(xfer_end), .halt(halt), .core_bus(core_bus),
        .grant_n(grant_n), .drv_oe(drv_oe), .local_owner(local_owner),
        .bus_out(bus_out)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            summary();
            $finish;
        end
    end

    initial begin
        tick(3);
        chk("R1 grant_n in reset", 32'(grant_n), 1);
        chk("R1 owner in reset", 32'(local_owner), 1);
        chk("R1 oe in reset", 32'(drv_oe), 1);
        rst_n = 1'b1;
        tick(1);
        chk("R1 grant_n after reset", 32'(grant_n), 1);
        chk("R1 owner after reset", 32'(local_owner), 1);

        // R2 R4 R5 R8: sweep boundary delay
        for (int d = 0; d < 6; d++) begin
            req_n = 1'b0;
            tick(3);
            chk("R2 no grant before boundary", 32'(grant_n), 1);
            tick(d);
            chk("R2 no grant while busy", 32'(grant_n), 1);
            xfer_end = 1'b1;
            tick(1);
            xfer_end = 1'b0;
            chk("R2 grant at boundary", 32'(grant_n), 0);
            chk("R4 owner drops", 32'(local_owner), 0);
            chk("R4 oe drops", 32'(drv_oe), 0);
            ack_n = 1'b0; req_n = 1'b1;
            tick(3 + NEG - 1);
            chk("R5 grant held before delay", 32'(grant_n), 0);
            tick(1);
            chk("R5 grant negated", 32'(grant_n), 1);
            ack_n = 1'b1;
            tick(3);
            chk("R8 not yet returned", 32'(local_owner), 0);
            tick(1);
            chk("R8 owner back", 32'(local_owner), 1);
            chk("R8 oe back", 32'(drv_oe), 1);
            tick(2);
        end

        // R7: withdrawal before acknowledge
        req_n = 1'b0; xfer_end = 1'b1;
        tick(4);
        xfer_end = 1'b0;
        chk("R7 granted", 32'(grant_n), 0);
        req_n = 1'b1;
        tick(2);
        chk("R7 grant held until sync", 32'(grant_n), 0);
        tick(1);
        chk("R7 grant removed", 32'(grant_n), 1);
        chk("R7 owner back", 32'(local_owner), 1);
        tick(2);

        // R6 R10: re-grant with request pending, handover
        req_n = 1'b0; xfer_end = 1'b1;
        tick(4);
        xfer_end = 1'b0;
        chk("R6 first grant", 32'(grant_n), 0);
        ack_n = 1'b0;
        tick(3 + NEG);
        chk("R5 negated with request pending", 32'(grant_n), 1);
        tick(RG - 1);
        chk("R6 no early re-grant", 32'(grant_n), 1);
        tick(1);
        chk("R6 re-grant", 32'(grant_n), 0);
        ack_n = 1'b1;
        tick(3);
        chk("R10 grant kept", 32'(grant_n), 0);
        chk("R10 core stays off", 32'(local_owner), 0);
        ack_n = 1'b0; req_n = 1'b1;
        tick(3 + NEG);
        chk("R10 second master negation", 32'(grant_n), 1);
        ack_n = 1'b1;
        tick(4);
        chk("R8 owner back after handover", 32'(local_owner), 1);
        tick(2);

        // R3 R9: arbitration while halted
        halt = 1'b1; core_bus = 30'h1234567;
        tick(2);
        req_n = 1'b0;
        tick(4);
        chk("R3 grant while halted", 32'(grant_n), 0);
        core_bus = 30'h2ABCDEF;
        tick(1);
        chk("R9 held while away", 32'(bus_out), 32'h1234567);
        ack_n = 1'b0; req_n = 1'b1;
        tick(3 + NEG);
        ack_n = 1'b1;
        tick(4);
        chk("R9 owner back halted", 32'(local_owner), 1);
        chk("R9 old value restored", 32'(bus_out), 32'h1234567);
        halt = 1'b0;
        tick(1);
        chk("R9 follows core after halt", 32'(bus_out), 32'h2ABCDEF);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule